// File: doc/BRIEF.md
# Vector and Scalar Dual-Issue Shader ALU

This block is one execution stage of a shader core. On every clock it takes one instruction bundle with two slots. The first slot holds a vector operation. It works on four lanes of 16-bit wrapping integers and has a per-lane write mask, so it can act as a 4-, 3-, 2- or 1-component operation. The second slot holds a scalar operation on a single selected component. The two slots are independent, and either one may be empty. Both read a shared register file and both write their results back at the same clock edge.

The scalar slot has no fused multiply-add. It does support add, multiply, a small group of one-operand functions, and an immediate load. The one-operand functions are simple integer operations that stand in for transcendental functions. The scalar slot keeps its latest result in a dedicated register. A later scalar operation can use that value as either operand without a trip through the register file. The same pairing rules apply to pixel work and vertex work, and no mode input changes them.

Results from a bundle are written at the clock edge that ends its issue cycle. The vector result, the retained scalar result and a write-conflict flag appear on registered outputs during the next cycle. A register's contents can be observed by issuing a vector MOV of that register.

Top module: `coissue_alu`

## Requirements
- R1: While `rst_n` is low, `vec_out`, `sca_prev` and `conflict` are zero and every register of the file is cleared. After reset, a vector MOV of any register returns zero.
- R2: Vector op codes are 0 ADD, 1 MUL, 2 MAD and 3 MOV. MAD computes a*b + (old destination lane). Every lane wraps modulo 2^16. All four computed lanes appear on `vec_out` (lane i at bits 16i+15:16i) one cycle after issue.
- R3: Bit i of `v_mask` enables the write of lane i of the destination. Lanes whose bit is clear keep their old value.
- R4: Lane i of each vector source takes component `swz[2i+1:2i]` of the named register. 8'hE4 is the identity swizzle.
- R5: Scalar op codes are 0 ADD, 1 MUL, 2 NEG (two's complement), 3 ABS, 4 SHR (logical shift right by one), 5 SATZ (negative values become zero), 6 MOV and 7 IMM (loads `s_imm`). The result is written to component `s_dst_comp` of `s_dst`.
- R6: When `s_a_prev` or `s_b_prev` is set, that scalar operand is the retained scalar result instead of a register component.
- R7: The retained scalar result, visible on `sca_prev`, resets to zero. It changes only on a cycle where `s_en` is high, so vector-only bundles leave it unchanged.
- R8: A vector operation and a scalar operation in the same bundle both execute, and both write back at the same edge.
- R9: When both slots write the same register, and the vector mask includes the scalar's component, the scalar value is stored in that component and `conflict` is high for the one following cycle. Otherwise `conflict` is low.
- R10: A register written by a bundle can be read by the very next bundle.
- R11: A slot whose enable is low writes nothing. When `v_en` is low, `vec_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| v_en | input | 1 | Vector slot present |
| v_op | input | 2 | Vector op code |
| v_dst | input | 4 | Vector destination register |
| v_src_a | input | 4 | Vector source A register |
| v_src_b | input | 4 | Vector source B register |
| v_swz_a | input | 8 | Source A swizzle, 2 bits per lane |
| v_swz_b | input | 8 | Source B swizzle, 2 bits per lane |
| v_mask | input | 4 | Vector lane write mask |
| s_en | input | 1 | Scalar slot present |
| s_op | input | 3 | Scalar op code |
| s_dst | input | 4 | Scalar destination register |
| s_dst_comp | input | 2 | Scalar destination component |
| s_src_a | input | 4 | Scalar source A register |
| s_comp_a | input | 2 | Scalar source A component |
| s_src_b | input | 4 | Scalar source B register |
| s_comp_b | input | 2 | Scalar source B component |
| s_a_prev | input | 1 | Source A is the retained scalar result |
| s_b_prev | input | 1 | Source B is the retained scalar result |
| s_imm | input | 16 | Immediate for scalar IMM |
| vec_out | output | 64 | Last vector result, all lanes |
| sca_prev | output | 16 | Retained scalar result |
| conflict | output | 1 | Same-component write collision in the last bundle |

## Verification
The bench uses the default parameters: 16-bit lanes, four lanes and sixteen registers. With these values, the signed and unsigned wrap points (0xFFFF + 0xFFFF, 0x8001 shifted right) can be reached using only a few immediate loads. All sixteen registers are addressable, so every test result can sit in its own register and be read back later. The fixed 2-bit swizzle fields allow exact cross-lane patterns such as reversal and broadcast to be checked against hand-computed lane values.

// File: rtl/coissue_pkg.sv
`timescale 1ns/1ps
package coissue_pkg;
   typedef enum logic [1:0] {
      VOP_ADD = 2'd0,
      VOP_MUL = 2'd1,
      VOP_MAD = 2'd2,
      VOP_MOV = 2'd3
   } vop_e;

   typedef enum logic [2:0] {
      SOP_ADD  = 3'd0,
      SOP_MUL  = 3'd1,
      SOP_NEG  = 3'd2,
      SOP_ABS  = 3'd3,
      SOP_SHR  = 3'd4,
      SOP_SATZ = 3'd5,
      SOP_MOV  = 3'd6,
      SOP_IMM  = 3'd7
   } sop_e;
endpackage

// File: rtl/coissue_rf.sv
`timescale 1ns/1ps
module coissue_rf #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4,
   parameter int DEPTH  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [$clog2(DEPTH)-1:0]      va_addr,
   input  logic [$clog2(DEPTH)-1:0]      vb_addr,
   input  logic [$clog2(DEPTH)-1:0]      vc_addr,
   output logic [LANES*LANE_W-1:0]       va_data,
   output logic [LANES*LANE_W-1:0]       vb_data,
   output logic [LANES*LANE_W-1:0]       vc_data,
   input  logic [$clog2(DEPTH)-1:0]      sa_addr,
   input  logic [$clog2(LANES)-1:0]      sa_comp,
   input  logic [$clog2(DEPTH)-1:0]      sb_addr,
   input  logic [$clog2(LANES)-1:0]      sb_comp,
   output logic [LANE_W-1:0]             sa_data,
   output logic [LANE_W-1:0]             sb_data,
   input  logic                          v_we,
   input  logic [$clog2(DEPTH)-1:0]      v_waddr,
   input  logic [LANES-1:0]              v_wmask,
   input  logic [LANES*LANE_W-1:0]       v_wdata,
   input  logic                          s_we,
   input  logic [$clog2(DEPTH)-1:0]      s_waddr,
   input  logic [$clog2(LANES)-1:0]      s_wlane,
   input  logic [LANE_W-1:0]             s_wdata
);
   localparam int VEC_W = LANES * LANE_W;

   logic [VEC_W-1:0] mem [DEPTH];

   assign va_data = mem[va_addr];
   assign vb_data = mem[vb_addr];
   assign vc_data = mem[vc_addr];
   assign sa_data = mem[sa_addr][int'(sa_comp)*LANE_W +: LANE_W];
   assign sb_data = mem[sb_addr][int'(sb_comp)*LANE_W +: LANE_W];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic hit_s, hit_v;
         assign hit_s = s_we && (int'(s_waddr) == e) && (int'(s_wlane) == l);
         assign hit_v = v_we && (int'(v_waddr) == e) && v_wmask[l];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[e][l*LANE_W +: LANE_W] <= '0;
            else if (hit_s)
               mem[e][l*LANE_W +: LANE_W] <= s_wdata;
            else if (hit_v)
               mem[e][l*LANE_W +: LANE_W] <= v_wdata[l*LANE_W +: LANE_W];
         end
      end
   end
endmodule

// File: rtl/coissue_vec.sv
`timescale 1ns/1ps
module coissue_vec
   import coissue_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input  vop_e                                 op,
   input  logic [LANES*LANE_W-1:0]              src_a,
   input  logic [LANES*LANE_W-1:0]              src_b,
   input  logic [LANES*LANE_W-1:0]              src_acc,
   input  logic [LANES*$clog2(LANES)-1:0]       swz_a,
   input  logic [LANES*$clog2(LANES)-1:0]       swz_b,
   output logic [LANES*LANE_W-1:0]              result
);
   localparam int CW = $clog2(LANES);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] a_i, b_i, acc_i, prod_i, r_i;
      assign a_i    = src_a[int'(swz_a[i*CW +: CW])*LANE_W +: LANE_W];
      assign b_i    = src_b[int'(swz_b[i*CW +: CW])*LANE_W +: LANE_W];
      assign acc_i  = src_acc[i*LANE_W +: LANE_W];
      assign prod_i = a_i * b_i;
      always_comb begin
         unique case (op)
            VOP_ADD: r_i = a_i + b_i;
            VOP_MUL: r_i = prod_i;
            VOP_MAD: r_i = prod_i + acc_i;
            default: r_i = a_i;
         endcase
      end
      assign result[i*LANE_W +: LANE_W] = r_i;
   end
endmodule

// File: rtl/coissue_sca.sv
`timescale 1ns/1ps
module coissue_sca
   import coissue_pkg::*;
#(
   parameter int LANE_W = 16
) (
   input  sop_e              op,
   input  logic [LANE_W-1:0] opa,
   input  logic [LANE_W-1:0] opb,
   input  logic [LANE_W-1:0] imm,
   output logic [LANE_W-1:0] result
);
   logic [LANE_W-1:0] neg_a;
   logic              a_neg;

   assign neg_a = ~opa + 1'b1;
   assign a_neg = opa[LANE_W-1];

   always_comb begin
      unique case (op)
         SOP_ADD:  result = opa + opb;
         SOP_MUL:  result = opa * opb;
         SOP_NEG:  result = neg_a;
         SOP_ABS:  result = a_neg ? neg_a : opa;
         SOP_SHR:  result = opa >> 1;
         SOP_SATZ: result = a_neg ? '0 : opa;
         SOP_MOV:  result = opa;
         default:  result = imm;
      endcase
   end
endmodule

// File: rtl/coissue_alu.sv
`timescale 1ns/1ps
module coissue_alu
   import coissue_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int LANES  = 4,
   parameter int REG_N  = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              v_en,
   input  logic [1:0]                        v_op,
   input  logic [$clog2(REG_N)-1:0]          v_dst,
   input  logic [$clog2(REG_N)-1:0]          v_src_a,
   input  logic [$clog2(REG_N)-1:0]          v_src_b,
   input  logic [LANES*$clog2(LANES)-1:0]    v_swz_a,
   input  logic [LANES*$clog2(LANES)-1:0]    v_swz_b,
   input  logic [LANES-1:0]                  v_mask,
   input  logic                              s_en,
   input  logic [2:0]                        s_op,
   input  logic [$clog2(REG_N)-1:0]          s_dst,
   input  logic [$clog2(LANES)-1:0]          s_dst_comp,
   input  logic [$clog2(REG_N)-1:0]          s_src_a,
   input  logic [$clog2(LANES)-1:0]          s_comp_a,
   input  logic [$clog2(REG_N)-1:0]          s_src_b,
   input  logic [$clog2(LANES)-1:0]          s_comp_b,
   input  logic                              s_a_prev,
   input  logic                              s_b_prev,
   input  logic [LANE_W-1:0]                 s_imm,
   output logic [LANES*LANE_W-1:0]           vec_out,
   output logic [LANE_W-1:0]                 sca_prev,
   output logic                              conflict
);
   localparam int VEC_W = LANES * LANE_W;

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (REG_N < 2 || (REG_N & (REG_N - 1)) != 0) begin : g_bad_depth
      $error("REG_N must be a power of two of at least 2");
   end
   if (LANE_W < 2) begin : g_bad_width
      $error("LANE_W must be at least 2");
   end

   logic [VEC_W-1:0]  rd_a, rd_b, rd_acc, vec_res;
   logic [LANE_W-1:0] rd_sa, rd_sb, opa, opb, sca_res;
   logic [LANE_W-1:0] prev_q;
   logic [VEC_W-1:0]  vec_q;
   logic              conf_q, collide;

   coissue_rf #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(REG_N)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .va_addr (v_src_a),
      .vb_addr (v_src_b),
      .vc_addr (v_dst),
      .va_data (rd_a),
      .vb_data (rd_b),
      .vc_data (rd_acc),
      .sa_addr (s_src_a),
      .sa_comp (s_comp_a),
      .sb_addr (s_src_b),
      .sb_comp (s_comp_b),
      .sa_data (rd_sa),
      .sb_data (rd_sb),
      .v_we    (v_en),
      .v_waddr (v_dst),
      .v_wmask (v_mask),
      .v_wdata (vec_res),
      .s_we    (s_en),
      .s_waddr (s_dst),
      .s_wlane (s_dst_comp),
      .s_wdata (sca_res)
   );

   coissue_vec #(.LANE_W(LANE_W), .LANES(LANES)) u_vec (
      .op      (vop_e'(v_op)),
      .src_a   (rd_a),
      .src_b   (rd_b),
      .src_acc (rd_acc),
      .swz_a   (v_swz_a),
      .swz_b   (v_swz_b),
      .result  (vec_res)
   );

   assign opa = s_a_prev ? prev_q : rd_sa;
   assign opb = s_b_prev ? prev_q : rd_sb;

   coissue_sca #(.LANE_W(LANE_W)) u_sca (
      .op     (sop_e'(s_op)),
      .opa    (opa),
      .opb    (opb),
      .imm    (s_imm),
      .result (sca_res)
   );

   assign collide = v_en && s_en && (v_dst == s_dst) && v_mask[s_dst_comp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q  <= '0;
         prev_q <= '0;
         conf_q <= 1'b0;
      end else begin
         if (v_en) vec_q  <= vec_res;
         if (s_en) prev_q <= sca_res;
         conf_q <= collide;
      end
   end

   assign vec_out  = vec_q;
   assign sca_prev = prev_q;
   assign conflict = conf_q;
endmodule

// File: rtl/coissue_alu_chk.sv
`timescale 1ns/1ps
module coissue_alu_chk #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4,
   parameter int REG_N  = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         v_en,
   input logic [$clog2(REG_N)-1:0]     v_dst,
   input logic [LANES-1:0]             v_mask,
   input logic                         s_en,
   input logic [2:0]                   s_op,
   input logic [$clog2(REG_N)-1:0]     s_dst,
   input logic [$clog2(LANES)-1:0]     s_dst_comp,
   input logic                         s_a_prev,
   input logic [LANE_W-1:0]            s_imm,
   input logic [LANES*LANE_W-1:0]      vec_out,
   input logic [LANE_W-1:0]            sca_prev,
   input logic                         conflict
);
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (vec_out == '0 && sca_prev == '0 && !conflict)); // R1

   AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !v_en |=> $stable(vec_out)); // R11

   AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !s_en |=> $stable(sca_prev)); // R7

   AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_en && s_op == 3'd7) |=> sca_prev == $past(s_imm)); // R5

   AST_NEG_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (s_en && s_op == 3'd2 && s_a_prev) |=> sca_prev == LANE_W'(~$past(sca_prev) + 1'b1)); // R6

   AST_CONFLICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conflict) |-> $past(v_en && s_en && v_dst == s_dst && v_mask[s_dst_comp])); // R9

   AST_NO_CONFLICT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(v_en && s_en) |=> !conflict); // R9
endmodule

bind coissue_alu coissue_alu_chk #(.LANE_W(LANE_W), .LANES(LANES), .REG_N(REG_N)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .v_en       (v_en),
   .v_dst      (v_dst),
   .v_mask     (v_mask),
   .s_en       (s_en),
   .s_op       (s_op),
   .s_dst      (s_dst),
   .s_dst_comp (s_dst_comp),
   .s_a_prev   (s_a_prev),
   .s_imm      (s_imm),
   .vec_out    (vec_out),
   .sca_prev   (sca_prev),
   .conflict   (conflict)
);

// File: tb/coissue_alu_test.sv
`timescale 1ns/1ps
module coissue_alu_test;
   typedef struct packed {
      logic        ve;  logic [1:0] vop; logic [3:0] vd; logic [3:0] va; logic [3:0] vb;
      logic [7:0]  swa; logic [7:0] swb; logic [3:0] vm;
      logic        se;  logic [2:0] sop; logic [3:0] sd; logic [1:0] sdc;
      logic [3:0]  sa;  logic [1:0] sca; logic [3:0] sb; logic [1:0] scb;
      logic        sap; logic sbp; logic [15:0] imm;
      logic [63:0] ev;  logic [15:0] ep; logic ec; int rq;
   } row_t;

   function automatic row_t mk(
      input logic ve, input logic [1:0] vop, input logic [3:0] vd, input logic [3:0] va,
      input logic [3:0] vb, input logic [7:0] swa, input logic [7:0] swb, input logic [3:0] vm,
      input logic se, input logic [2:0] sop, input logic [3:0] sd, input logic [1:0] sdc,
      input logic [3:0] sa, input logic [1:0] sca, input logic [3:0] sb, input logic [1:0] scb,
      input logic sap, input logic sbp, input logic [15:0] imm,
      input logic [63:0] ev, input logic [15:0] ep, input logic ec, input int rq);
      row_t r;
      r = '{ve, vop, vd, va, vb, swa, swb, vm, se, sop, sd, sdc, sa, sca, sb, scb,
            sap, sbp, imm, ev, ep, ec, rq};
      return r;
   endfunction

   localparam int NROWS = 29;
   localparam row_t TBL [NROWS] = '{
      // R5: immediate loads build r1 = {0002,FFFF,0005,0003}
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,7,1,0,0,0,0,0,0,0,16'h0003, 64'h0, 16'h0003,0,5),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,7,1,1,0,0,0,0,0,0,16'h0005, 64'h0, 16'h0005,0,5),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,7,1,2,0,0,0,0,0,0,16'hFFFF, 64'h0, 16'hFFFF,0,5),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,7,1,3,0,0,0,0,0,0,16'h0002, 64'h0, 16'h0002,0,5),
      // R10: r1 written last cycle is read now
      mk(1,3,2,1,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0002FFFF00050003, 16'h0002,0,10),
      // R2: ADD with lane wrap
      mk(1,0,3,1,2,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0004FFFE000A0006, 16'h0002,0,2),
      // R3: MUL, mask lanes 0 and 1 only
      mk(1,1,4,1,3,8'hE4,8'hE4,4'h3, 0,0,0,0,0,0,0,0,0,0,0, 64'h0008000200320012, 16'h0002,0,3),
      mk(1,3,5,4,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0000000000320012, 16'h0002,0,3),
      // R2: MAD accumulates into old r4
      mk(1,2,4,1,1,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h00040001004B001B, 16'h0002,0,2),
      // R4: reversed swizzle, then broadcast of component 0
      mk(1,3,6,1,0,8'h1B,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h00030005FFFF0002, 16'h0002,0,4),
      mk(1,0,7,1,1,8'hE4,8'h00,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0005000200080006, 16'h0002,0,4),
      // R5 scalar ADD, R6 chained operands
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,0,8,0,1,1,1,2,0,0,0, 64'h0005000200080006, 16'h0004,0,5),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,1,8,1,1,0,0,0,0,1,0, 64'h0005000200080006, 16'h000C,0,6),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,2,0,0,0,0,0,0,1,0,0, 64'h0005000200080006, 16'hFFF4,0,6),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,3,0,0,0,0,0,0,1,0,0, 64'h0005000200080006, 16'h000C,0,5),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,2,0,0,0,0,0,0,1,0,0, 64'h0005000200080006, 16'hFFF4,0,5),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,5,0,0,0,0,0,0,1,0,0, 64'h0005000200080006, 16'h0000,0,5),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,7,0,0,0,0,0,0,0,0,16'h8001, 64'h0005000200080006, 16'h8001,0,5),
      mk(0,0,0,0,0,8'hE4,8'hE4,0, 1,4,0,0,0,0,0,0,1,0,0, 64'h0005000200080006, 16'h4000,0,5),
      // R7: vector-only bundle leaves the retained value
      mk(1,3,9,1,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0002FFFF00050003, 16'h4000,0,7),
      // R8: co-issue
      mk(1,0,10,1,1,8'hE4,8'hE4,4'hF, 1,0,11,2,0,0,1,0,1,0,0, 64'h0004FFFE000A0006, 16'h4003,0,8),
      // R9: collision, scalar wins
      mk(1,3,12,1,0,8'hE4,8'hE4,4'hF, 1,7,12,1,0,0,0,0,0,0,16'h7777, 64'h0002FFFF00050003, 16'h7777,1,9),
      mk(1,3,13,12,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0002FFFF77770003, 16'h7777,0,9),
      // R9: same register, masked-off lane: no collision
      mk(1,3,14,1,0,8'hE4,8'hE4,4'hD, 1,7,14,1,0,0,0,0,0,0,16'h1111, 64'h0002FFFF00050003, 16'h1111,0,9),
      mk(1,3,13,14,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0002FFFF11110003, 16'h1111,0,3),
      mk(1,3,13,11,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0000400300000000, 16'h1111,0,8),
      mk(1,3,13,8,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h00000000000C0004, 16'h1111,0,5),
      // R11: empty bundle
      mk(0,3,13,1,0,8'hE4,8'hE4,4'hF, 0,7,1,0,0,0,0,0,0,0,16'hABCD, 64'h00000000000C0004, 16'h1111,0,11),
      mk(1,3,13,4,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h00040001004B001B, 16'h1111,0,2)
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic v_en, s_en, s_a_prev, s_b_prev;
   logic [1:0] v_op, s_dst_comp, s_comp_a, s_comp_b;
   logic [2:0] s_op;
   logic [3:0] v_dst, v_src_a, v_src_b, v_mask, s_dst, s_src_a, s_src_b;
   logic [7:0] v_swz_a, v_swz_b;
   logic [15:0] s_imm, sca_prev;
   logic [63:0] vec_out;
   logic conflict;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   coissue_alu uut (
      .clk(clk), .rst_n(rst_n), .v_en(v_en), .v_op(v_op), .v_dst(v_dst),
      .v_src_a(v_src_a), .v_src_b(v_src_b), .v_swz_a(v_swz_a), .v_swz_b(v_swz_b),
      .v_mask(v_mask), .s_en(s_en), .s_op(s_op), .s_dst(s_dst), .s_dst_comp(s_dst_comp),
      .s_src_a(s_src_a), .s_comp_a(s_comp_a), .s_src_b(s_src_b), .s_comp_b(s_comp_b),
      .s_a_prev(s_a_prev), .s_b_prev(s_b_prev), .s_imm(s_imm),
      .vec_out(vec_out), .sca_prev(sca_prev), .conflict(conflict));

   task automatic apply(input row_t r);
      @(negedge clk);
      v_en = r.ve; v_op = r.vop; v_dst = r.vd; v_src_a = r.va; v_src_b = r.vb;
      v_swz_a = r.swa; v_swz_b = r.swb; v_mask = r.vm;
      s_en = r.se; s_op = r.sop; s_dst = r.sd; s_dst_comp = r.sdc;
      s_src_a = r.sa; s_comp_a = r.sca; s_src_b = r.sb; s_comp_b = r.scb;
      s_a_prev = r.sap; s_b_prev = r.sbp; s_imm = r.imm;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input int rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic check_row(input row_t r);
      check(r.rq, "vec_out", vec_out, r.ev);
      check(r.rq, "sca_prev", {48'h0, sca_prev}, {48'h0, r.ep});
      check(r.rq, "conflict", {63'h0, conflict}, {63'h0, r.ec});
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      row_t idle, rd;
      idle = mk(0,0,0,0,0,8'hE4,8'hE4,0, 0,0,0,0,0,0,0,0,0,0,0, 64'h0,16'h0,0,1);
      v_en = 0; v_op = 0; v_dst = 0; v_src_a = 0; v_src_b = 0; v_swz_a = 8'hE4; v_swz_b = 8'hE4;
      v_mask = 0; s_en = 0; s_op = 0; s_dst = 0; s_dst_comp = 0; s_src_a = 0; s_comp_a = 0;
      s_src_b = 0; s_comp_b = 0; s_a_prev = 0; s_b_prev = 0; s_imm = 0;
      repeat (3) @(posedge clk);
      #1;
      check_row(idle);                       // R1 outputs during reset
      @(negedge clk); rst_n = 1'b1;
      // R1: a register reads zero after reset
      rd = mk(1,3,13,15,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0,16'h0,0,1);
      apply(rd);
      check_row(rd);
      for (int i = 0; i < NROWS; i++) begin
         apply(TBL[i]);
         check_row(TBL[i]);
      end
      // R11: disabled slots aimed at r1 leave it unchanged
      apply(mk(0,3,1,15,0,8'hE4,8'hE4,4'hF, 0,7,1,0,0,0,0,0,0,0,16'h5555, 64'h0,16'h0,0,11));
      rd = mk(1,3,13,1,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0002FFFF00050003,16'h1111,0,11);
      apply(rd);
      check_row(rd);
      // R1: reset mid-run clears outputs and registers
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1;
      check_row(idle);
      @(negedge clk); rst_n = 1'b1;
      rd = mk(1,3,13,1,0,8'hE4,8'hE4,4'hF, 0,0,0,0,0,0,0,0,0,0,0, 64'h0,16'h0,0,1);
      apply(rd);
      check_row(rd);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule